// File: doc/BRIEF.md
# Fixed-Point Logical Execution Unit

This unit executes the logical instruction group of a 64-bit fixed-point core. Each issued instruction supplies a 10-bit extended opcode, a record bit, two 64-bit source operands (`srcS`, `srcB`) and the current summary-overflow bit. The unit computes one of twelve operations:

- eight bitwise functions;
- sign extension of a byte or a halfword;
- a leading-zero count over the low word;
- a byte-wise equality mask.

It returns the 64-bit destination value, a 4-bit condition field with its write strobe, and an illegal-opcode flag.

The unit is a single registered stage with no handshake. An input marked valid produces its outputs exactly one clock later, alongside `outValid`. A decoder upstream guarantees that the opcode belongs to the logical group or reports it. The unit itself flags any value it does not recognise and suppresses every side effect of that value.

Top module: `fxlogic_unit`

## Requirements
- R1: The bitwise opcodes give these results: 28 = S&B, 444 = S|B, 316 = S^B, 476 = ~(S&B), 124 = ~(S|B), 284 = ~(S^B), 60 = S&~B and 412 = S|~B.
- R2: Opcode 954 returns bits 7:0 of `srcS` sign-extended to 64 bits. Opcode 922 does the same for bits 15:0. `srcB` has no effect on either result.
- R3: Opcode 26 returns the number of leading zeros in bits 31:0 of `srcS`, zero-extended. The result is 32 when those bits are all zero, and bits 63:32 of `srcS` have no effect.
- R4: Opcode 508 sets result byte k to 0xFF when byte k of `srcS` equals byte k of `srcB`, and to 0x00 otherwise, for k = 0..7.
- R5: For every legal opcode except 508, `crWrite` equals the record bit. `crField` is {LT,GT,EQ,SO} in bits 3..0. LT, GT and EQ come from a signed comparison of the result with zero, and SO is a copy of `soIn`.
- R6: Opcode 508 never asserts `crWrite`, whatever the record bit says.
- R7: Any other opcode asserts `illegalOp`, forces `result` to zero and keeps `crWrite` low.
- R8: Outputs appear one cycle after an input with `inValid` high, and `outValid` follows `inValid` with one cycle of delay. Synchronous reset clears `outValid`. `crWrite` and `illegalOp` are only high while `outValid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Input instruction is valid |
| extOp | input | 10 | Extended opcode |
| rcFlag | input | 1 | Record bit: request a condition-field update |
| srcS | input | 64 | First source operand |
| srcB | input | 64 | Second source operand |
| soIn | input | 1 | Current summary-overflow bit |
| outValid | output | 1 | Outputs hold a completed instruction |
| result | output | 64 | Destination value |
| crField | output | 4 | Condition field {LT,GT,EQ,SO} |
| crWrite | output | 1 | Condition field write enable |
| illegalOp | output | 1 | Opcode not recognised |

## Verification
The leading-zero count is driven with a low word of zero while the upper word is set. A design that counts over 64 bits, or that wraps to zero, returns the wrong value.

The byte compare is driven with the record bit set and with fully equal, fully different and partly equal operand pairs. A design that writes the condition field for this opcode, or that compares only the low word, is exposed.

Negative byte and halfword inputs are paired with a nonzero `srcB`. This catches zero extension and any leak of the second operand.

Results whose top bit is set check that LT uses a signed comparison. Unknown opcodes arrive with the record bit high to show that both the result and the condition write are suppressed.

// File: rtl/fxlogic_pkg.sv
package fxlogic_pkg;

  localparam int OPC_W = 10;

  localparam logic [OPC_W-1:0] XO_AND    = 10'd28;
  localparam logic [OPC_W-1:0] XO_XOR    = 10'd316;
  localparam logic [OPC_W-1:0] XO_NAND   = 10'd476;
  localparam logic [OPC_W-1:0] XO_OR     = 10'd444;
  localparam logic [OPC_W-1:0] XO_NOR    = 10'd124;
  localparam logic [OPC_W-1:0] XO_ANDC   = 10'd60;
  localparam logic [OPC_W-1:0] XO_EQV    = 10'd284;
  localparam logic [OPC_W-1:0] XO_ORC    = 10'd412;
  localparam logic [OPC_W-1:0] XO_SEXT8  = 10'd954;
  localparam logic [OPC_W-1:0] XO_SEXT16 = 10'd922;
  localparam logic [OPC_W-1:0] XO_CLZ    = 10'd26;
  localparam logic [OPC_W-1:0] XO_BYTEEQ = 10'd508;

  typedef enum logic [2:0] {
    UNIT_NONE, UNIT_BOOL, UNIT_SEXT8, UNIT_SEXT16, UNIT_CLZ, UNIT_BYTEEQ
  } unit_e;

  typedef enum logic [1:0] { FN_AND, FN_OR, FN_XOR } boolfn_e;

  typedef struct packed {
    unit_e   unit;
    boolfn_e fn;
    logic    invB;
    logic    invOut;
    logic    crAllowed;
    logic    illegal;
  } strobe_t;

endpackage

// File: rtl/fxlogic_ctrl.sv
module fxlogic_ctrl
  import fxlogic_pkg::*;
(
  input  logic [OPC_W-1:0] extOp,
  output strobe_t          stb
);

  always_comb begin
    stb = '{unit: UNIT_BOOL, fn: FN_AND, invB: 1'b0, invOut: 1'b0,
            crAllowed: 1'b1, illegal: 1'b0};
    unique case (extOp)
      XO_AND:    ;
      XO_NAND:   stb.invOut = 1'b1;
      XO_ANDC:   stb.invB = 1'b1;
      XO_OR:     stb.fn = FN_OR;
      XO_NOR:    begin stb.fn = FN_OR; stb.invOut = 1'b1; end
      XO_ORC:    begin stb.fn = FN_OR; stb.invB = 1'b1; end
      XO_XOR:    stb.fn = FN_XOR;
      XO_EQV:    begin stb.fn = FN_XOR; stb.invOut = 1'b1; end
      XO_SEXT8:  stb.unit = UNIT_SEXT8;
      XO_SEXT16: stb.unit = UNIT_SEXT16;
      XO_CLZ:    stb.unit = UNIT_CLZ;
      XO_BYTEEQ: begin stb.unit = UNIT_BYTEEQ; stb.crAllowed = 1'b0; end
      default: begin
        stb.unit      = UNIT_NONE;
        stb.crAllowed = 1'b0;
        stb.illegal   = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/fxlogic_dp.sv
module fxlogic_dp
  import fxlogic_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int CLZ_W  = 32
) (
  input  strobe_t           stb,
  input  logic [DATA_W-1:0] srcS,
  input  logic [DATA_W-1:0] srcB,
  input  logic              soIn,
  output logic [DATA_W-1:0] resNext,
  output logic [3:0]        crNext
);

  localparam int NBYTES = DATA_W / 8;
  localparam int CNT_W  = $clog2(CLZ_W + 1);

  logic [DATA_W-1:0] opB;
  logic [DATA_W-1:0] boolRaw;
  logic [DATA_W-1:0] boolRes;
  logic [DATA_W-1:0] byteEqMask;
  logic [CNT_W-1:0]  lzCount;

  assign opB = stb.invB ? ~srcB : srcB;

  always_comb begin
    unique case (stb.fn)
      FN_OR:   boolRaw = srcS | opB;
      FN_XOR:  boolRaw = srcS ^ opB;
      default: boolRaw = srcS & opB;
    endcase
  end

  assign boolRes = stb.invOut ? ~boolRaw : boolRaw;

  for (genvar g = 0; g < NBYTES; g++) begin : g_byteEq
    assign byteEqMask[g*8 +: 8] = {8{srcS[g*8 +: 8] == srcB[g*8 +: 8]}};
  end

  always_comb begin
    lzCount = CNT_W'(CLZ_W);
    for (int i = 0; i < CLZ_W; i++) begin
      if (srcS[i]) lzCount = CNT_W'(CLZ_W - 1 - i);
    end
  end

  always_comb begin
    unique case (stb.unit)
      UNIT_BOOL:   resNext = boolRes;
      UNIT_SEXT8:  resNext = {{(DATA_W-8){srcS[7]}}, srcS[7:0]};
      UNIT_SEXT16: resNext = {{(DATA_W-16){srcS[15]}}, srcS[15:0]};
      UNIT_CLZ:    resNext = DATA_W'(lzCount);
      UNIT_BYTEEQ: resNext = byteEqMask;
      default:     resNext = '0;
    endcase
  end

  assign crNext = {resNext[DATA_W-1],
                   ~resNext[DATA_W-1] & (|resNext),
                   ~(|resNext),
                   soIn};

endmodule

// File: rtl/fxlogic_unit.sv
module fxlogic_unit
  import fxlogic_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int CLZ_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [9:0]        extOp,
  input  logic              rcFlag,
  input  logic [DATA_W-1:0] srcS,
  input  logic [DATA_W-1:0] srcB,
  input  logic              soIn,
  output logic              outValid,
  output logic [DATA_W-1:0] result,
  output logic [3:0]        crField,
  output logic              crWrite,
  output logic              illegalOp
);

  strobe_t           stb;
  logic [DATA_W-1:0] resNext;
  logic [3:0]        crNext;
  logic              crWrQ;
  logic              illQ;

  fxlogic_ctrl ctrl_i (
    .extOp (extOp),
    .stb   (stb)
  );

  fxlogic_dp #(.DATA_W(DATA_W), .CLZ_W(CLZ_W)) dp_i (
    .stb     (stb),
    .srcS    (srcS),
    .srcB    (srcB),
    .soIn    (soIn),
    .resNext (resNext),
    .crNext  (crNext)
  );

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= inValid;
  end

  always_ff @(posedge clk) begin
    if (inValid) begin
      result  <= resNext;
      crField <= crNext;
      crWrQ   <= rcFlag & stb.crAllowed;
      illQ    <= stb.illegal;
    end
  end

  assign crWrite   = outValid & crWrQ;
  assign illegalOp = outValid & illQ;

endmodule

// File: rtl/fxlogic_unit_chk.sv
module fxlogic_unit_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              inValid,
  input logic [9:0]        extOp,
  input logic              rcFlag,
  input logic [DATA_W-1:0] srcS,
  input logic [DATA_W-1:0] srcB,
  input logic              soIn,
  input logic              outValid,
  input logic [DATA_W-1:0] result,
  input logic [3:0]        crField,
  input logic              crWrite,
  input logic              illegalOp
);

  p_valid_follows_r8: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);
  p_bubble_r8: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);
  p_flags_need_valid_r8: assert property (@(posedge clk) disable iff (rst)
    (crWrite || illegalOp) |-> outValid);
  p_illegal_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    illegalOp |-> (result == '0) && !crWrite);
  p_byteeq_no_cr_r6: assert property (@(posedge clk) disable iff (rst)
    inValid && extOp == 10'd508 |=> !crWrite);
  p_byteeq_equal_r4: assert property (@(posedge clk) disable iff (rst)
    inValid && extOp == 10'd508 && srcS == srcB |=> result == '1);
  p_clz_zero_r3: assert property (@(posedge clk) disable iff (rst)
    inValid && extOp == 10'd26 && srcS[31:0] == '0 |=> result == DATA_W'(32));
  p_cr_and_rc_r5: assert property (@(posedge clk) disable iff (rst)
    inValid && rcFlag && extOp == 10'd28 |=> crWrite);
  p_cr_onehot_r5: assert property (@(posedge clk) disable iff (rst)
    crWrite |-> $countones(crField[3:1]) == 1);
  p_cr_so_r5: assert property (@(posedge clk) disable iff (rst)
    crWrite |-> crField[0] == $past(soIn));

endmodule

bind fxlogic_unit fxlogic_unit_chk #(.DATA_W(DATA_W)) chk_i (.*);

// File: tb/fxlogic_unit_tb_top.sv
`timescale 1ns/1ps
module fxlogic_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [9:0]  extOp = '0;
  logic        rcFlag = 1'b0;
  logic [63:0] srcS = '0;
  logic [63:0] srcB = '0;
  logic        soIn = 1'b0;
  logic        outValid;
  logic [63:0] result;
  logic [3:0]  crField;
  logic        crWrite;
  logic        illegalOp;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  fxlogic_unit dut_i (.*);

  typedef struct {
    logic        v;
    logic [63:0] r;
    logic [3:0]  cr;
    logic        crw;
    logic        ill;
    string       tag;
  } exp_t;

  exp_t q[$];

  function automatic exp_t model(logic v, logic [9:0] op, logic rc,
                                 logic [63:0] s, logic [63:0] b, logic so);
    exp_t e;
    int n;
    logic [63:0] m;
    e.v = v; e.ill = 1'b0; e.r = '0;
    case (op)
      10'd28:  begin e.r = s & b;     e.tag = "R1"; end
      10'd316: begin e.r = s ^ b;     e.tag = "R1"; end
      10'd476: begin e.r = ~(s & b);  e.tag = "R1"; end
      10'd444: begin e.r = s | b;     e.tag = "R1"; end
      10'd124: begin e.r = ~(s | b);  e.tag = "R1"; end
      10'd60:  begin e.r = s & ~b;    e.tag = "R1"; end
      10'd284: begin e.r = ~(s ^ b);  e.tag = "R1"; end
      10'd412: begin e.r = s | ~b;    e.tag = "R1"; end
      10'd954: begin e.r = 64'($signed(s[7:0]));  e.tag = "R2"; end
      10'd922: begin e.r = 64'($signed(s[15:0])); e.tag = "R2"; end
      10'd26: begin
        n = 0;
        while (n < 32 && !s[31-n]) n++;
        e.r = 64'(n); e.tag = "R3";
      end
      10'd508: begin
        m = 64'hFF;
        for (int k = 0; k < 8; k++) begin
          if ((s & m) == (b & m)) e.r |= m;
          m = m << 8;
        end
        e.tag = "R4";
      end
      default: begin e.ill = 1'b1; e.tag = "R7"; end
    endcase
    if ($signed(e.r) < 0)   e.cr = 4'b1000;
    else if (e.r != 0)      e.cr = 4'b0100;
    else                    e.cr = 4'b0010;
    e.cr[0] = so;
    e.crw = v && rc && !e.ill && op != 10'd508;
    return e;
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] expv);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, expv, $time);
    end
  endtask

  task automatic compareOutputs();
    exp_t e;
    if (q.size() == 0) return;
    e = q.pop_front();
    chk(outValid === e.v, "R8", 64'(outValid), 64'(e.v));
    if (!e.v) begin
      chk(crWrite === 1'b0 && illegalOp === 1'b0, "R8",
          {62'd0, crWrite, illegalOp}, 64'd0);
      return;
    end
    chk(result === e.r, e.tag, result, e.r);
    chk(illegalOp === e.ill, "R7", 64'(illegalOp), 64'(e.ill));
    chk(crWrite === e.crw, e.tag == "R4" ? "R6" : "R5", 64'(crWrite), 64'(e.crw));
    if (e.crw) chk(crField === e.cr, "R5", 64'(crField), 64'(e.cr));
  endtask

  task automatic step(logic v, logic [9:0] op, logic rc,
                      logic [63:0] s, logic [63:0] b, logic so);
    @(negedge clk);
    compareOutputs();
    inValid = v; extOp = op; rcFlag = rc; srcS = s; srcB = b; soIn = so;
    q.push_back(model(v, op, rc, s, b, so));
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog R8 actual=hung expected=done");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    logic [9:0]  ops [12];
    logic [63:0] sv  [8];
    logic [63:0] bv  [8];
    ops = '{10'd28, 10'd316, 10'd476, 10'd444, 10'd124, 10'd60,
            10'd284, 10'd412, 10'd954, 10'd922, 10'd26, 10'd508};
    sv = '{64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0080,
           64'hFFFF_FFFF_0000_0000, 64'h0123_4567_89AB_CDEF,
           64'h0123_4567_89AB_CDEF, 64'h0000_0000_0001_8000,
           64'h1122_3344_5566_7788};
    bv = '{64'h0, 64'h0, 64'hDEAD_BEEF_0000_1234, 64'h5A5A_5A5A_5A5A_5A5A,
           64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210,
           64'h7FFF_0000_0000_FFFF, 64'h1122_0044_5500_7788};

    repeat (3) @(negedge clk);
    chk(outValid === 1'b0, "R8", 64'(outValid), 64'd0);
    rst = 1'b0;

    for (int rc = 0; rc < 2; rc++) begin
      for (int o = 0; o < 12; o++) begin
        for (int p = 0; p < 8; p++) begin
          step(1'b1, ops[o], rc[0], sv[p], bv[p], p[0]);
        end
        step(1'b0, ops[o], rc[0], sv[0], bv[0], 1'b0);
      end
    end

    step(1'b1, 10'd0,    1'b1, sv[1], bv[1], 1'b1);
    step(1'b1, 10'd27,   1'b1, sv[2], bv[2], 1'b0);
    step(1'b1, 10'd1023, 1'b1, sv[4], bv[5], 1'b1);
    step(1'b1, 10'd509,  1'b1, sv[7], bv[7], 1'b0);
    step(1'b1, 10'd954,  1'b1, 64'h0000_0000_0000_00FF, 64'hFFFF, 1'b1);
    step(1'b1, 10'd922,  1'b0, 64'h1234_5678_0000_8001, 64'h1, 1'b0);
    step(1'b1, 10'd26,   1'b1, 64'hFFFF_FFFF_0000_0001, 64'h0, 1'b1);

    step(1'b1, 10'd28, 1'b1, sv[1], sv[1], 1'b1);
    @(negedge clk);
    rst = 1'b1;
    inValid = 1'b0;
    q.delete();
    @(negedge clk);
    chk(outValid === 1'b0, "R8", 64'(outValid), 64'd0);
    rst = 1'b0;
    step(1'b0, 10'd28, 1'b0, 64'h0, 64'h0, 1'b0);
    step(1'b0, 10'd28, 1'b0, 64'h0, 64'h0, 1'b0);
    @(negedge clk);
    compareOutputs();

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule